// File: doc/BRIEF.md
# Dual-Mode ATA Channel Address Decoder

This block sits between a host I/O bus and two parallel ATA channels, primary and secondary. Each host read or write is compared against every range that is enabled. Each channel has an 8-byte command-register window and a 4-byte control-register window. On a hit, the block asserts the chip select for that window and the read or write strobe for that channel. It also drives the 3-bit drive register address. The drive registers themselves live in the drive, not here.

A mode input chooses between two sets of bases. In fixed mode the bases are hardwired: command 0x1F0 and control 0x3F4 for primary, and command 0x170 and control 0x374 for secondary. In programmable mode the bases come from four base registers, which are loaded through a write port. Only one set decodes at a time. A global I/O enable and a per-channel enable gate all matching.

For control-window hits, drive address bit 2 is always driven high. A programmable control base only needs 4-byte alignment, so the host address bit 2 may be 0, yet the drive must still see its alternate-status or device-control register. All outputs are registered. An access that hits no range raises `unclaimed_o` for one cycle.

Top module: `ide_port_decoder`

## Requirements
- R1: While `rst_ni` is low, every chip select and strobe is high (inactive), `da_o` is 0 and `unclaimed_o` is 0.
- R2: In fixed mode (`native_mode_i`=0), an access to 0x1F0..0x1F7 drives `cs1_n_o[0]` low, and an access to 0x170..0x177 drives `cs1_n_o[1]` low. In both cases the channel's address field is set to address bits [2:0]. `da_o[2:0]` is the primary field and `da_o[5:3]` the secondary field.
- R3: In fixed mode, an access to 0x3F4..0x3F7 drives `cs3_n_o[0]` low, and an access to 0x374..0x377 drives `cs3_n_o[1]` low. The channel's address field is {1, addr[1:0]}.
- R4: A pulse on `base_wr_i` loads `base_data_i` into the base register picked by `base_sel_i`: 0 primary command, 1 primary control, 2 secondary command, 3 secondary control. Bits [2:0] of a command base and bits [1:0] of a control base are stored as 0. In programmable mode these registers set the windows.
- R5: In fixed mode the programmable bases do not decode. In programmable mode the fixed addresses do not decode.
- R6: With `io_space_en_i`=0 no access is claimed. With `chan_en_i[c]`=0, channel c claims nothing.
- R7: A claimed read pulls the channel's `dior_n_o` low and a claimed write pulls its `diow_n_o` low. The strobe appears in the cycle after the access is presented and lasts one cycle per access cycle.
- R8: Every control-window hit drives the channel's address bit 2 high, even when host address bit 2 is 0.
- R9: When windows overlap, the order of precedence is primary command, then primary control, then secondary command, then secondary control. At most one chip select is active.
- R10: An access that hits no enabled range leaves all chip selects and strobes high and raises `unclaimed_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_valid_i | input | 1 | Host I/O access present this cycle |
| io_write_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | 16 | Host I/O address |
| native_mode_i | input | 1 | 1 = programmable bases, 0 = fixed bases |
| io_space_en_i | input | 1 | Global I/O decode enable |
| chan_en_i | input | 2 | Per-channel decode enable (bit 0 primary) |
| base_wr_i | input | 1 | Base register write pulse |
| base_sel_i | input | 2 | Base register select |
| base_data_i | input | 16 | Base register write data |
| cs1_n_o | output | 2 | Command-window chip selects, active low |
| cs3_n_o | output | 2 | Control-window chip selects, active low |
| dior_n_o | output | 2 | Read strobes, active low |
| diow_n_o | output | 2 | Write strobes, active low |
| da_o | output | 6 | Drive address, [2:0] primary, [5:3] secondary |
| unclaimed_o | output | 1 | Access hit no range |

## Verification
The functions that can fall in the same cycle are the priority resolution and the control-window address forcing. Several windows can claim one address, and the control window's bit-2 rewrite must apply only when that window actually wins. The bench provokes the collision by programming the two command bases equal, and by placing the primary control base inside the primary command window. It judges each case from the chip select that wins and from the address field of the winning channel, while the losing channel must stay silent.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int ADDR_W  = 16;
  localparam int NCH     = 2;
  localparam int CMD_LG  = 3;  // 8-byte command window
  localparam int CTL_LG  = 2;  // 4-byte control window

  function automatic logic [ADDR_W-1:0] fixed_cmd_base(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [ADDR_W-1:0] fixed_ctl_base(input int ch);
    return (ch == 0) ? 16'h03F4 : 16'h0374;
  endfunction
endpackage

// File: rtl/ide_base_regs.sv
module ide_base_regs
  import ide_dec_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NC    = NCH,
  localparam int SELW = $clog2(2*NC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [SELW-1:0]        sel_i,
  input  logic [AW-1:0]          data_i,
  output logic [NC-1:0][AW-1:0]  cmd_base_o,
  output logic [NC-1:0][AW-1:0]  ctl_base_o
);
  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [AW-1:CMD_LG] cmd_q;
    logic [AW-1:CTL_LG] ctl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmd_q <= '0;
        ctl_q <= '0;
      end else if (wr_i && (int'(sel_i) >> 1) == c) begin
        if (sel_i[0]) ctl_q <= data_i[AW-1:CTL_LG];
        else          cmd_q <= data_i[AW-1:CMD_LG];
      end
    end

    assign cmd_base_o[c] = {cmd_q, {CMD_LG{1'b0}}};
    assign ctl_base_o[c] = {ctl_q, {CTL_LG{1'b0}}};

    AST_BASE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && int'(sel_i) == 2*c) |=>
        cmd_base_o[c][AW-1:CMD_LG] == $past(data_i[AW-1:CMD_LG])); // R4
  end
endmodule

// File: rtl/ide_range_match.sv
module ide_range_match #(
  parameter int AW      = 16,
  parameter int SPAN_LG = 3
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  output logic          hit_o
);
  assign hit_o = en_i && (addr_i[AW-1:SPAN_LG] == base_i[AW-1:SPAN_LG]);
endmodule

// File: rtl/ide_prio_pick.sv
module ide_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end
endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
  import ide_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_valid_i,
  input  logic              io_write_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              native_mode_i,
  input  logic              io_space_en_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic              base_wr_i,
  input  logic [1:0]        base_sel_i,
  input  logic [ADDR_W-1:0] base_data_i,
  output logic [NCH-1:0]    cs1_n_o,
  output logic [NCH-1:0]    cs3_n_o,
  output logic [NCH-1:0]    dior_n_o,
  output logic [NCH-1:0]    diow_n_o,
  output logic [3*NCH-1:0]  da_o,
  output logic              unclaimed_o
);
  localparam int NWIN = 2*NCH;

  logic [NCH-1:0][ADDR_W-1:0] reg_cmd_base, reg_ctl_base;
  logic [NWIN-1:0]            hit, gnt;
  logic [NCH-1:0]             cs1_d, cs3_d, dior_d, diow_d;
  logic [3*NCH-1:0]           da_d;
  logic                       unc_d;

  ide_base_regs #(.AW(ADDR_W), .NC(NCH)) u_base (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (base_wr_i),
    .sel_i      (base_sel_i),
    .data_i     (base_data_i),
    .cmd_base_o (reg_cmd_base),
    .ctl_base_o (reg_ctl_base)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_win
    logic [ADDR_W-1:0] cmd_b, ctl_b;
    logic              en;
    assign cmd_b = native_mode_i ? reg_cmd_base[c] : fixed_cmd_base(c);
    assign ctl_b = native_mode_i ? reg_ctl_base[c] : fixed_ctl_base(c);
    assign en    = io_valid_i && io_space_en_i && chan_en_i[c];

    ide_range_match #(.AW(ADDR_W), .SPAN_LG(CMD_LG)) u_cmd (
      .en_i(en), .addr_i(io_addr_i), .base_i(cmd_b), .hit_o(hit[2*c]));
    ide_range_match #(.AW(ADDR_W), .SPAN_LG(CTL_LG)) u_ctl (
      .en_i(en), .addr_i(io_addr_i), .base_i(ctl_b), .hit_o(hit[2*c+1]));

    logic claim;
    assign claim     = gnt[2*c] | gnt[2*c+1];
    assign cs1_d[c]  = ~gnt[2*c];
    assign cs3_d[c]  = ~gnt[2*c+1];
    assign dior_d[c] = ~(claim && !io_write_i);
    assign diow_d[c] = ~(claim && io_write_i);
    // control window: DA2 forced high for alignment-safe register selection
    assign da_d[3*c +: 3] = gnt[2*c]   ? io_addr_i[2:0] :
                            gnt[2*c+1] ? {1'b1, io_addr_i[1:0]} : 3'b000;
  end

  ide_prio_pick #(.N(NWIN)) u_pick (.req_i(hit), .gnt_o(gnt));

  assign unc_d = io_valid_i && !(|gnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs1_n_o     <= '1;
      cs3_n_o     <= '1;
      dior_n_o    <= '1;
      diow_n_o    <= '1;
      da_o        <= '0;
      unclaimed_o <= 1'b0;
    end else begin
      cs1_n_o     <= cs1_d;
      cs3_n_o     <= cs3_d;
      dior_n_o    <= dior_d;
      diow_n_o    <= diow_d;
      da_o        <= da_d;
      unclaimed_o <= unc_d;
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~cs1_n_o, ~cs3_n_o})); // R9
  AST_UNCLAIMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unclaimed_o |-> (&cs1_n_o && &cs3_n_o && &dior_n_o && &diow_n_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_valid_i |=> (&cs1_n_o && &cs3_n_o && !unclaimed_o)); // R7
  AST_IO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_i && !io_space_en_i) |=> unclaimed_o); // R6

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_CTL_DA2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs3_n_o[c] |-> da_o[3*c+2]); // R8
    AST_STROBE_HAS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dior_n_o[c] || !diow_n_o[c]) |-> (!cs1_n_o[c] || !cs3_n_o[c])); // R7
    AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(!dior_n_o[c] && !diow_n_o[c])); // R7
  end
endmodule

// File: tb/ide_port_decoder_tb_top.sv
module ide_port_decoder_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_valid = 0, io_write = 0;
  logic [15:0] io_addr = '0;
  logic        native = 0, io_en = 1;
  logic [1:0]  chan_en = 2'b11;
  logic        base_wr = 0;
  logic [1:0]  base_sel = '0;
  logic [15:0] base_data = '0;
  logic [1:0]  cs1_n, cs3_n, dior_n, diow_n;
  logic [5:0]  da;
  logic        unc;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  ide_port_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_valid_i(io_valid), .io_write_i(io_write),
    .io_addr_i(io_addr), .native_mode_i(native), .io_space_en_i(io_en),
    .chan_en_i(chan_en), .base_wr_i(base_wr), .base_sel_i(base_sel),
    .base_data_i(base_data), .cs1_n_o(cs1_n), .cs3_n_o(cs3_n),
    .dior_n_o(dior_n), .diow_n_o(diow_n), .da_o(da), .unclaimed_o(unc));

  // win: -1 none, 0 pri cmd, 1 pri ctl, 2 sec cmd, 3 sec ctl
  function automatic logic [14:0] expv(int win, bit wr, logic [2:0] dav, bit u);
    logic [1:0] c1 = 2'b11, c3 = 2'b11, rd = 2'b11, wt = 2'b11;
    logic [5:0] d = '0;
    if (win >= 0) begin
      int ch = win / 2;
      if (win % 2 == 0) c1[ch] = 1'b0; else c3[ch] = 1'b0;
      if (wr) wt[ch] = 1'b0; else rd[ch] = 1'b0;
      d[3*ch +: 3] = dav;
    end
    return {c1, c3, rd, wt, d, u};
  endfunction

  task automatic check(string req, logic [14:0] exp);
    logic [14:0] act = {cs1_n, cs3_n, dior_n, diow_n, da, unc};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // present one access, sample the registered result, then go idle
  task automatic access(string req, logic [15:0] a, bit wr, logic [14:0] exp);
    io_valid = 1; io_write = wr; io_addr = a;
    @(negedge clk);
    io_valid = 0;
    check(req, exp);
  endtask

  task automatic set_base(logic [1:0] sel, logic [15:0] v);
    base_wr = 1; base_sel = sel; base_data = v;
    @(negedge clk);
    base_wr = 0;
  endtask

  task automatic t_reset;
    check("R1", expv(-1, 0, 3'd0, 0));
  endtask

  task automatic t_fixed_cmd;
    native = 0;
    access("R2", 16'h01F0, 0, expv(0, 0, 3'd0, 0));
    access("R2", 16'h01F7, 1, expv(0, 1, 3'd7, 0));
    access("R2", 16'h0175, 0, expv(2, 0, 3'd5, 0));
    @(negedge clk);
    check("R7", expv(-1, 0, 3'd0, 0));
  endtask

  task automatic t_fixed_ctl;
    access("R3", 16'h03F6, 0, expv(1, 0, 3'd6, 0));
    access("R3", 16'h0374, 1, expv(3, 1, 3'd4, 0));
  endtask

  task automatic t_native;
    native = 1;
    set_base(2'd0, 16'h1235);           // stored as 0x1230
    set_base(2'd3, 16'h2009);           // stored as 0x2008
    access("R4", 16'h1233, 0, expv(0, 0, 3'd3, 0));
    access("R4", 16'h1237, 1, expv(0, 1, 3'd7, 0));
    access("R4", 16'h1238, 0, expv(-1, 0, 3'd0, 1));
    access("R8", 16'h200A, 0, expv(3, 0, 3'd6, 0));
    access("R8", 16'h2008, 1, expv(3, 1, 3'd4, 0));
  endtask

  task automatic t_exclusive;
    native = 1;
    access("R5", 16'h01F0, 0, expv(-1, 0, 3'd0, 1));
    native = 0;
    access("R5", 16'h1233, 0, expv(-1, 0, 3'd0, 1));
  endtask

  task automatic t_enables;
    native = 0;
    io_en = 0;
    access("R6", 16'h01F0, 0, expv(-1, 0, 3'd0, 1));
    io_en = 1; chan_en = 2'b10;
    access("R6", 16'h01F0, 0, expv(-1, 0, 3'd0, 1));
    access("R6", 16'h0170, 1, expv(2, 1, 3'd0, 0));
    chan_en = 2'b11;
  endtask

  task automatic t_priority;
    native = 1;
    set_base(2'd2, 16'h1230);           // secondary cmd overlaps primary cmd
    set_base(2'd1, 16'h1234);           // primary ctl inside primary cmd
    access("R9", 16'h1231, 0, expv(0, 0, 3'd1, 0));
    access("R9", 16'h1235, 1, expv(0, 1, 3'd5, 0));
    chan_en = 2'b10;
    access("R9", 16'h1231, 0, expv(2, 0, 3'd1, 0));
    chan_en = 2'b11;
  endtask

  task automatic t_miss;
    native = 0;
    access("R10", 16'h0300, 1, expv(-1, 0, 3'd0, 1));
    @(negedge clk);
    check("R10", expv(-1, 0, 3'd0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fixed_cmd();
    t_fixed_ctl();
    t_native();
    t_exclusive();
    t_enables();
    t_priority();
    t_miss();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule